// File: doc/BRIEF.md
# Flash Erase and Protection Controller

This block sits between a small processor's register bus and the command port of an on-chip program flash. Software loads a page number or arms a mass erase, then writes a trigger code. The block turns that into one erase command for the flash interface and stays busy until the flash reports completion. Before it issues a page erase it checks the page against two write-protected regions: a boot region at the bottom of the array and an upper region at the top. A page erase that hits an enabled region is dropped and a violation flag is raised.

A sticky security bit can be set by software but cleared only by a hardware reset. While it is set, both write-protect bits can only be raised. A program-write enable steers the processor's data-space write stream either to data RAM (the default) or to the flash programming port. That stream uses valid/ready: the selected sink's ready is passed straight back, the other sink sees no valid, and address and data must be held while valid is high and ready is low.

The register map uses four word addresses. Address 0 is control. Address 1 is the page register. Address 2 is the trigger. Address 3 is status, which is read-only except for a write-one-to-clear violation bit. Pages are 1024 bytes each, so a region of N kilobytes covers N pages.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, control (addr 0), page (addr 1) and status (addr 3) all read 0 while the preboot input is low.
- R2: With a page written to addr 1 since the last page trigger, and the page outside every enabled protected region, writing 0x5A to addr 2 raises cmd_valid on the next cycle. It also drives cmd_mass=0 and cmd_page equal to the page. The page-valid flag (status bit 3) clears.
- R3: Writing 0x A5 to addr 2 while the mass arm (control bit 1, write-only, reads 0) is set issues a command with cmd_mass=1 and clears the arm. Without the arm the write issues nothing.
- R4: Writing 0x5A with no fresh page write issues nothing. A trigger value other than 0x5A or 0xA5 issues nothing and leaves the arm unchanged.
- R5: Busy (status bit 0) rises with the command and falls on the cycle after flash_done. Trigger writes made while busy are ignored.
- R6: cmd_valid, cmd_mass and cmd_page hold steady until cmd_ready is seen. cmd_valid drops on the cycle after the handshake.
- R7: With boot protect (control bit 2) set, a page trigger for a page below BOOT_KB issues nothing, sets the violation flag (status bit 1) and clears page-valid. Writing 1 to status bit 1 clears the violation flag.
- R8: With upper protect (control bit 3) set, a page trigger for a page at or above UPPER_KB is dropped in the same way.
- R9: The security bit (control bit 4) is set by writing 1, ignores writes of 0, and clears only on reset.
- R10: While security is 1, the protect bits ignore writes of 0 and accept writes of 1. While security is 0, they follow the written value.
- R11: With program-write enable (control bit 0) at 1, xw_valid goes to pf_valid and xw_ready follows pf_ready. At 0, they go to ram_valid and ram_ready. Address and data pass to both sinks unchanged.
- R12: Status bit 2 follows the preboot input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| preboot_i | input | 1 | Preboot sequence active |
| cmd_valid | output | 1 | Erase command valid |
| cmd_ready | input | 1 | Flash accepts command |
| cmd_mass | output | 1 | 1 = mass erase, 0 = page erase |
| cmd_page | output | 7 | Page to erase |
| flash_done | input | 1 | Flash erase completed |
| xw_valid | input | 1 | Data-space write valid |
| xw_ready | output | 1 | Data-space write ready |
| xw_addr | input | 16 | Data-space write address |
| xw_data | input | 8 | Data-space write data |
| ram_valid | output | 1 | Write valid toward data RAM |
| ram_ready | input | 1 | Data RAM ready |
| pf_valid | output | 1 | Write valid toward program flash |
| pf_ready | input | 1 | Program flash ready |
| sink_addr | output | 16 | Address to both sinks |
| sink_data | output | 8 | Data to both sinks |

## Verification
A stale page-valid or arm flag shows up on the very next trigger as a command that should not exist, or as one that is missing on cmd_valid. A wrong busy state shows up as a swallowed or a doubled command, visible within one trigger. A protect or security bit that slips shows up as soon as control is read back, or on the next page trigger as a missing or spurious violation. Route errors show up in the same cycle on the sink valids.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;
  localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] A_PAGE = 2'd1;
  localparam logic [REG_AW-1:0] A_TRIG = 2'd2;
  localparam logic [REG_AW-1:0] A_STAT = 2'd3;

  localparam int CB_PWE  = 0;
  localparam int CB_ARM  = 1;
  localparam int CB_PLO  = 2;
  localparam int CB_PHI  = 3;
  localparam int CB_SEC  = 4;

  localparam int SB_BUSY = 0;
  localparam int SB_VIOL = 1;
  localparam int SB_PRE  = 2;
  localparam int SB_PGV  = 3;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REQ, SEQ_WAIT} seq_state_t;

  typedef struct packed {
    logic secure;
    logic prot_hi;
    logic prot_lo;
    logic mass_arm;
    logic prog_wen;
  } ctrl_t;
endpackage

// File: rtl/flash_erase_regs.sv
module flash_erase_regs
  import flash_erase_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              consume_mass,
  input  logic              consume_page,
  input  logic              viol_set,
  output ctrl_t             ctrl,
  output logic [PAGE_W-1:0] page,
  output logic              page_valid,
  output logic              viol
);
  logic wr_ctrl, wr_page, wr_stat;
  assign wr_ctrl = we && (addr == A_CTRL);
  assign wr_page = we && (addr == A_PAGE);
  assign wr_stat = we && (addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (consume_mass) ctrl.mass_arm <= 1'b0;
      if (wr_ctrl) begin
        ctrl.prog_wen <= wdata[CB_PWE];
        ctrl.mass_arm <= wdata[CB_ARM];
        ctrl.secure   <= ctrl.secure | wdata[CB_SEC];
        ctrl.prot_lo  <= ctrl.secure ? (ctrl.prot_lo | wdata[CB_PLO]) : wdata[CB_PLO];
        ctrl.prot_hi  <= ctrl.secure ? (ctrl.prot_hi | wdata[CB_PHI]) : wdata[CB_PHI];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page       <= '0;
      page_valid <= 1'b0;
    end else begin
      if (consume_page) page_valid <= 1'b0;
      if (wr_page) begin
        page       <= wdata[PAGE_W-1:0];
        page_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        viol <= 1'b0;
    else if (viol_set)                 viol <= 1'b1;
    else if (wr_stat && wdata[SB_VIOL]) viol <= 1'b0;
  end
endmodule

// File: rtl/flash_erase_prot.sv
module flash_erase_prot #(
  parameter int PAGE_W   = 7,
  parameter int BOOT_KB  = 8,
  parameter int UPPER_KB = 120
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              prot_lo,
  input  logic              prot_hi,
  output logic              hit
);
  localparam int NPAGES = 1 << PAGE_W;
  logic lo_hit, hi_hit;

  generate
    if (BOOT_KB > 0) begin : g_lo
      assign lo_hit = prot_lo && (int'(page) < BOOT_KB);
    end else begin : g_lo_none
      assign lo_hit = 1'b0;
    end
    if (UPPER_KB < NPAGES) begin : g_hi
      assign hi_hit = prot_hi && (int'(page) >= UPPER_KB);
    end else begin : g_hi_none
      assign hi_hit = 1'b0;
    end
  endgenerate

  assign hit = lo_hit | hi_hit;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int               PAGE_W    = 7,
  parameter logic [REG_DW-1:0] MASS_CODE = 8'hA5,
  parameter logic [REG_DW-1:0] PAGE_CODE = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              mass_arm,
  input  logic              page_valid,
  input  logic [PAGE_W-1:0] page,
  input  logic              prot_hit,
  input  logic              cmd_ready,
  input  logic              flash_done,
  output logic              consume_mass,
  output logic              consume_page,
  output logic              viol_set,
  output logic              cmd_valid,
  output logic              cmd_mass,
  output logic [PAGE_W-1:0] cmd_page,
  output logic              busy
);
  seq_state_t st;
  logic trig, fire_mass, page_try, fire_page;

  assign trig      = we && (addr == A_TRIG) && (st == SEQ_IDLE);
  assign fire_mass = trig && (wdata == MASS_CODE) && mass_arm;
  assign page_try  = trig && (wdata == PAGE_CODE) && page_valid;
  assign fire_page = page_try && !prot_hit;

  assign consume_mass = fire_mass;
  assign consume_page = page_try;
  assign viol_set     = page_try && prot_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      cmd_mass <= 1'b0;
      cmd_page <= '0;
    end else begin
      unique case (st)
        SEQ_IDLE: begin
          if (fire_mass) begin
            st       <= SEQ_REQ;
            cmd_mass <= 1'b1;
            cmd_page <= '0;
          end else if (fire_page) begin
            st       <= SEQ_REQ;
            cmd_mass <= 1'b0;
            cmd_page <= page;
          end
        end
        SEQ_REQ:  if (cmd_ready)  st <= SEQ_WAIT;
        SEQ_WAIT: if (flash_done) st <= SEQ_IDLE;
        default:  st <= SEQ_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st == SEQ_REQ);
  assign busy      = (st != SEQ_IDLE);
endmodule

// File: rtl/flash_erase_route.sv
module flash_erase_route #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          prog_wen,
  input  logic          xw_valid,
  output logic          xw_ready,
  input  logic [AW-1:0] xw_addr,
  input  logic [DW-1:0] xw_data,
  output logic          ram_valid,
  input  logic          ram_ready,
  output logic          pf_valid,
  input  logic          pf_ready,
  output logic [AW-1:0] sink_addr,
  output logic [DW-1:0] sink_data
);
  assign ram_valid = xw_valid && !prog_wen;
  assign pf_valid  = xw_valid &&  prog_wen;
  assign xw_ready  = prog_wen ? pf_ready : ram_ready;
  assign sink_addr = xw_addr;
  assign sink_data = xw_data;
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int PAGE_W   = 7,
  parameter int BOOT_KB  = 8,
  parameter int UPPER_KB = 120,
  parameter int XAW      = 16,
  parameter int XDW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              preboot_i,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_mass,
  output logic [PAGE_W-1:0] cmd_page,
  input  logic              flash_done,
  input  logic              xw_valid,
  output logic              xw_ready,
  input  logic [XAW-1:0]    xw_addr,
  input  logic [XDW-1:0]    xw_data,
  output logic              ram_valid,
  input  logic              ram_ready,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [XAW-1:0]    sink_addr,
  output logic [XDW-1:0]    sink_data
);
  ctrl_t             ctrl;
  logic [PAGE_W-1:0] page;
  logic              page_valid, viol, busy, prot_hit;
  logic              consume_mass, consume_page, viol_set;

  flash_erase_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .consume_mass(consume_mass), .consume_page(consume_page), .viol_set(viol_set),
    .ctrl(ctrl), .page(page), .page_valid(page_valid), .viol(viol)
  );

  flash_erase_prot #(.PAGE_W(PAGE_W), .BOOT_KB(BOOT_KB), .UPPER_KB(UPPER_KB)) u_prot (
    .page(page), .prot_lo(ctrl.prot_lo), .prot_hi(ctrl.prot_hi), .hit(prot_hit)
  );

  flash_erase_seq #(.PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .mass_arm(ctrl.mass_arm), .page_valid(page_valid), .page(page), .prot_hit(prot_hit),
    .cmd_ready(cmd_ready), .flash_done(flash_done),
    .consume_mass(consume_mass), .consume_page(consume_page), .viol_set(viol_set),
    .cmd_valid(cmd_valid), .cmd_mass(cmd_mass), .cmd_page(cmd_page), .busy(busy)
  );

  flash_erase_route #(.AW(XAW), .DW(XDW)) u_route (
    .prog_wen(ctrl.prog_wen), .xw_valid(xw_valid), .xw_ready(xw_ready),
    .xw_addr(xw_addr), .xw_data(xw_data), .ram_valid(ram_valid), .ram_ready(ram_ready),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .sink_addr(sink_addr), .sink_data(sink_data)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[CB_PWE] = ctrl.prog_wen;
        reg_rdata[CB_PLO] = ctrl.prot_lo;
        reg_rdata[CB_PHI] = ctrl.prot_hi;
        reg_rdata[CB_SEC] = ctrl.secure;
      end
      A_PAGE: reg_rdata[PAGE_W-1:0] = page;
      A_STAT: begin
        reg_rdata[SB_BUSY] = busy;
        reg_rdata[SB_VIOL] = viol;
        reg_rdata[SB_PRE]  = preboot_i;
        reg_rdata[SB_PGV]  = page_valid;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_erase_ctrl_chk.sv
module flash_erase_ctrl_chk #(
  parameter int PAGE_W  = 7,
  parameter int BOOT_KB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_mass,
  input logic [PAGE_W-1:0] cmd_page,
  input logic              flash_done,
  input logic              busy,
  input logic              secure,
  input logic              prot_lo,
  input logic              prot_hi,
  input logic              ram_valid,
  input logic              pf_valid
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_mass) && $stable(cmd_page)); // R6
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy); // R5
  AST_SECURE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    secure |=> secure); // R9
  AST_PLO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    secure && prot_lo |=> prot_lo); // R10
  AST_PHI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    secure && prot_hi |=> prot_hi); // R10
  AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) && !cmd_mass && prot_lo |-> int'(cmd_page) >= BOOT_KB); // R7
  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_valid && pf_valid)); // R11
endmodule

bind flash_erase_ctrl flash_erase_ctrl_chk #(.PAGE_W(PAGE_W), .BOOT_KB(BOOT_KB)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_mass(cmd_mass), .cmd_page(cmd_page), .flash_done(flash_done), .busy(busy),
  .secure(ctrl.secure), .prot_lo(ctrl.prot_lo), .prot_hi(ctrl.prot_hi),
  .ram_valid(ram_valid), .pf_valid(pf_valid)
);

// File: tb/flash_erase_ctrl_tb.sv
module flash_erase_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BOOT_KB = 8;
  localparam int UPPER_KB = 120;
  localparam logic [7:0] MC = 8'hA5;
  localparam logic [7:0] PC = 8'h5A;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [1:0] reg_addr = 0; logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic preboot_i = 0, cmd_valid, cmd_ready = 0, cmd_mass, flash_done = 0;
  logic [6:0] cmd_page;
  logic xw_valid = 0, xw_ready, ram_valid, ram_ready = 0, pf_valid, pf_ready = 0;
  logic [15:0] xw_addr = 0, sink_addr; logic [7:0] xw_data = 0, sink_data;

  int n_chk = 0, n_fail = 0; bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_ctrl dut_i (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit prot_exp(int p, bit lo, bit hi);
    return (lo && p < BOOT_KB) || (hi && p >= UPPER_KB);
  endfunction

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic serve(int lat, bit em, int ep, string tag);
    logic [7:0] s;
    chk({tag, " cmd_valid"}, cmd_valid, 1);
    chk({tag, " cmd_mass"}, cmd_mass, em);
    if (!em) chk({tag, " cmd_page"}, cmd_page, ep);
    rd(2'd3, s); chk("R5 busy at issue", s[0], 1);
    repeat (lat) @(negedge clk);
    chk("R6 valid held", cmd_valid, 1);
    chk("R6 page held", em ? 0 : cmd_page, em ? 0 : ep);
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
    chk("R6 valid drops after handshake", cmd_valid, 0);
    repeat (2) @(negedge clk);
    rd(2'd3, s); chk("R5 busy until done", s[0], 1);
    flash_done = 1; @(negedge clk); flash_done = 0;
    rd(2'd3, s); chk("R5 busy falls", s[0], 0);
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    @(negedge clk); do_reset();

    // R1 reset values
    rd(2'd0, d); chk("R1 ctrl reset", d, 0);
    rd(2'd1, d); chk("R1 page reset", d, 0);
    rd(2'd3, d); chk("R1 status reset", d, 0);
    // R12 preboot
    preboot_i = 1; rd(2'd3, d); chk("R12 preboot shown", d[2], 1);
    preboot_i = 0; rd(2'd3, d); chk("R12 preboot low", d[2], 0);

    // R4 page code with no fresh page
    wr(2'd2, PC); chk("R4 no page no cmd", cmd_valid, 0);
    // R3 mass without arm
    wr(2'd2, MC); chk("R3 unarmed mass ignored", cmd_valid, 0);
    // R4 other code keeps arm
    wr(2'd0, 8'h02); wr(2'd2, 8'h33); chk("R4 other code ignored", cmd_valid, 0);
    rd(2'd0, d); chk("R3 arm reads 0", d[1], 0);
    wr(2'd2, MC); serve(2, 1, 0, "R3 mass");
    wr(2'd2, MC); chk("R3 arm cleared after issue", cmd_valid, 0);

    // R2 page erase, R5 trigger during busy
    wr(2'd1, 8'd40); rd(2'd3, d); chk("R2 page valid set", d[3], 1);
    wr(2'd0, 8'h02);
    wr(2'd2, PC);
    rd(2'd3, d); chk("R2 page valid cleared", d[3], 0);
    wr(2'd2, MC);
    serve(1, 0, 40, "R2 page");
    chk("R5 busy trigger ignored", cmd_valid, 0);
    wr(2'd2, MC); serve(0, 1, 0, "R5 arm kept across busy");

    // R7 / R8 random protection
    for (int i = 0; i < 60; i++) begin
      int p; bit lo, hi;
      p = $urandom_range(127);
      if (i % 4 == 0) p = (i % 8 == 0) ? BOOT_KB - 1 : UPPER_KB;
      if (i % 4 == 1) p = (i % 8 == 1) ? BOOT_KB : UPPER_KB - 1;
      lo = $urandom_range(1); hi = $urandom_range(1);
      wr(2'd0, {4'b0, hi, lo, 2'b00});
      wr(2'd1, p[7:0]);
      wr(2'd2, PC);
      if (prot_exp(p, lo, hi)) begin
        chk(p < 64 ? "R7 boot drop" : "R8 upper drop", cmd_valid, 0);
        rd(2'd3, d); chk("R7 viol set", d[1], 1);
        chk("R7 page valid cleared on drop", d[3], 0);
        wr(2'd3, 8'h02); rd(2'd3, d); chk("R7 viol cleared", d[1], 0);
      end else begin
        rd(2'd3, d); chk("R8 no viol", d[1], 0);
        serve($urandom_range(3), 0, p, "R8 allowed page");
      end
    end

    // R11 routing
    xw_valid = 1; xw_addr = 16'h1234; xw_data = 8'hC3; ram_ready = 1; pf_ready = 0; #1;
    chk("R11 ram valid", ram_valid, 1); chk("R11 pf idle", pf_valid, 0);
    chk("R11 ram ready", xw_ready, 1); chk("R11 addr", sink_addr, 16'h1234);
    wr(2'd0, 8'h01); #1;
    chk("R11 pf valid", pf_valid, 1); chk("R11 ram idle", ram_valid, 0);
    chk("R11 pf ready", xw_ready, 0); chk("R11 data", sink_data, 8'hC3);
    xw_valid = 0;

    // R9 / R10 security
    wr(2'd0, 8'h14); rd(2'd0, d); chk("R9 secure set", d, 8'h14);
    wr(2'd0, 8'h00); rd(2'd0, d); chk("R10 frozen lo, R9 sticky", d, 8'h14);
    wr(2'd0, 8'h08); rd(2'd0, d); chk("R10 hi may rise", d, 8'h1C);
    wr(2'd1, 8'd3); wr(2'd2, PC); chk("R7 secure drop", cmd_valid, 0);
    wr(2'd3, 8'h02);
    do_reset();
    rd(2'd0, d); chk("R9 reset clears secure", d, 0);
    wr(2'd0, 8'h04); wr(2'd0, 8'h00); rd(2'd0, d); chk("R10 free when unsecured", d, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule